// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a 32-bit virtual address into a physical address by fetching descriptors from a two-level translation table in memory. A client presents the virtual address together with the table base while the block is idle. The block then issues one read for the first-level descriptor, and a second read when that descriptor points to a second-level table. Reads go out over a request/grant/read-data port that allows one read in flight at a time.

When the walk finishes, the block raises `done_o` for one cycle. A successful walk returns the physical address, a mapping-size code, the 4-bit domain from the first-level descriptor, the cacheable and bufferable attributes, and the 2-bit permission field that applies to the addressed subpage. A failed walk reports a translation fault and the level that failed. The block does not cache translations and does not enforce permissions or domains; both jobs belong to the surrounding TLB.

Top module: `tt_walker`

## Requirements
- R1: After reset `req_ready_o` is 1 and both `mem_req_o` and `done_o` are 0.
- R2: A request is taken only when `req_ready_o` is 1. The first read goes to `{ttb_i[31:14], va[31:20], 2'b00}`, using the values captured when the request was taken.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk after that single read, with `fault_o`=1 and `fault_lvl_o`=0.
- R4: A first-level descriptor with bits [1:0] = 10 and bit 18 clear returns `pa_o = {desc[31:20], va[19:0]}` and `size_o` = 3. It also returns the domain from desc[8:5], `cacheable_o` from desc[3], `bufferable_o` from desc[2] and `ap_o` from desc[11:10].
- R5: Bits [1:0] = 10 with bit 18 set returns `pa_o = {desc[31:24], va[23:0]}` and `size_o` = 4. The other attributes are taken as in R4.
- R6: Bits [1:0] = 01 select a second read at `{desc[31:10], va[19:12], 2'b00}`.
- R7: Bits [1:0] = 11 select a second read at `{desc[31:12], va[19:10], 2'b00}`.
- R8: A second-level descriptor with bits [1:0] = 00 gives `fault_o`=1 and `fault_lvl_o`=1.
- R9: Second-level type 01 returns `pa_o = {desc[31:16], va[15:0]}` and `size_o` = 2. `ap_o` is the 2-bit field at desc[4+2k +: 2], where k = va[15:14].
- R10: Second-level type 10 returns `pa_o = {desc[31:12], va[11:0]}` and `size_o` = 1. `ap_o` is the field at desc[4+2k +: 2], where k = va[11:10].
- R11: Second-level type 11 returns `pa_o = {desc[31:10], va[9:0]}`, `size_o` = 0 and `ap_o` = desc[5:4], whatever va[11:10] is.
- R12: For a second-level result, `domain_o` comes from the first-level descriptor bits [8:5]. `cacheable_o` and `bufferable_o` come from second-level bits 3 and 2.
- R13: `mem_req_o` and `mem_addr_o` stay unchanged until `mem_gnt_i` is seen.
- R14: `done_o` lasts exactly one cycle. Requests presented during a walk are ignored: they start no reads and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ttb_i | input | 32 | Table base; bits [31:14] are used |
| req_valid_i | input | 1 | Walk request |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Block idle, request can be taken |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor word address (byte address, low bits zero) |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor read data |
| done_o | output | 1 | Walk result valid, one cycle |
| fault_o | output | 1 | Translation fault |
| fault_lvl_o | output | 1 | Failing level: 0 first, 1 second |
| pa_o | output | 32 | Physical address |
| size_o | output | 3 | 0 1K, 1 4K, 2 64K, 3 1M, 4 16M |
| domain_o | output | 4 | Domain number |
| cacheable_o | output | 1 | Cacheable attribute |
| bufferable_o | output | 1 | Bufferable attribute |
| ap_o | output | 2 | Permission field of the addressed subpage |

## Verification
The block is built with its package defaults: 32-bit addresses, 4-bit domains and 2-bit permission fields. These are the widths the descriptor layouts fix. The bench's own parameter `GNT_STALL` defaults to 2, so every descriptor read waits two cycles for its grant. That exposes the request-hold behaviour on every read, both first-level and second-level. Setting it to 0 exercises back-to-back grants on the same walks.

// File: rtl/tt_walk_pkg.sv
package tt_walk_pkg;
  localparam int unsigned AW    = 32;
  localparam int unsigned DOM_W = 4;
  localparam int unsigned AP_W  = 2;
  localparam int unsigned SZ_W  = 3;

  typedef enum logic [SZ_W-1:0] {
    SZ_1K = 3'd0, SZ_4K = 3'd1, SZ_64K = 3'd2, SZ_1M = 3'd3, SZ_16M = 3'd4
  } map_size_e;

  typedef enum logic [1:0] {
    K1_FAULT = 2'b00, K1_COARSE = 2'b01, K1_SECT = 2'b10, K1_FINE = 2'b11
  } l1_kind_e;

  typedef struct packed {
    logic [AW-1:0]   pa;
    map_size_e       size;
    logic            c;
    logic            b;
    logic [AP_W-1:0] ap;
  } map_res_t;
endpackage

// File: rtl/tt_l1_decode.sv
module tt_l1_decode
  import tt_walk_pkg::*;
(
  input  logic [AW-1:0]    va_i,
  input  logic [AW-1:0]    desc_i,
  output l1_kind_e         kind_o,
  output logic [AW-1:0]    l2_addr_o,
  output logic [DOM_W-1:0] dom_o,
  output map_res_t         sect_o
);
  always_comb begin
    kind_o = l1_kind_e'(desc_i[1:0]);
    dom_o  = desc_i[8:5];
    // fine table: 4 KB, 1024 entries; coarse: 1 KB, 256 entries
    if (desc_i[1:0] == 2'b11) l2_addr_o = {desc_i[31:12], va_i[19:10], 2'b00};
    else                      l2_addr_o = {desc_i[31:10], va_i[19:12], 2'b00};
    sect_o.c  = desc_i[3];
    sect_o.b  = desc_i[2];
    sect_o.ap = desc_i[11:10];
    if (desc_i[18]) begin
      sect_o.pa   = {desc_i[31:24], va_i[23:0]};
      sect_o.size = SZ_16M;
    end else begin
      sect_o.pa   = {desc_i[31:20], va_i[19:0]};
      sect_o.size = SZ_1M;
    end
  end
endmodule

// File: rtl/tt_l2_decode.sv
module tt_l2_decode
  import tt_walk_pkg::*;
(
  input  logic [AW-1:0] va_i,
  input  logic [AW-1:0] desc_i,
  output logic          fault_o,
  output map_res_t      res_o
);
  logic [1:0] sub_sel;

  always_comb begin
    fault_o  = (desc_i[1:0] == 2'b00);
    res_o.c  = desc_i[3];
    res_o.b  = desc_i[2];
    sub_sel  = 2'd0;
    unique case (desc_i[1:0])
      2'b01: begin
        res_o.pa   = {desc_i[31:16], va_i[15:0]};
        res_o.size = SZ_64K;
        sub_sel    = va_i[15:14];
      end
      2'b10: begin
        res_o.pa   = {desc_i[31:12], va_i[11:0]};
        res_o.size = SZ_4K;
        sub_sel    = va_i[11:10];
      end
      2'b11: begin
        res_o.pa   = {desc_i[31:10], va_i[9:0]};
        res_o.size = SZ_1K;
      end
      default: begin
        res_o.pa   = '0;
        res_o.size = SZ_1K;
      end
    endcase
    res_o.ap = desc_i[4 + 2*sub_sel +: AP_W];
  end
endmodule

// File: rtl/tt_walker.sv
module tt_walker
  import tt_walk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ttb_i,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    req_va_i,
  output logic             req_ready_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic             fault_lvl_o,
  output logic [AW-1:0]    pa_o,
  output logic [SZ_W-1:0]  size_o,
  output logic [DOM_W-1:0] domain_o,
  output logic             cacheable_o,
  output logic             bufferable_o,
  output logic [AP_W-1:0]  ap_o
);
  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
  } walk_state_e;

  walk_state_e      state_q;
  logic [AW-1:0]    va_q, ttb_q, l2_addr_q;
  logic [DOM_W-1:0] dom_q;
  map_res_t         res_q;
  logic             fault_q, flvl_q;

  l1_kind_e         l1_kind;
  logic [AW-1:0]    l1_l2_addr;
  logic [DOM_W-1:0] l1_dom;
  map_res_t         l1_sect;
  logic             l2_fault;
  map_res_t         l2_res;

  tt_l1_decode i_l1_dec (
    .va_i(va_q), .desc_i(mem_rdata_i), .kind_o(l1_kind),
    .l2_addr_o(l1_l2_addr), .dom_o(l1_dom), .sect_o(l1_sect)
  );

  tt_l2_decode i_l2_dec (
    .va_i(va_q), .desc_i(mem_rdata_i), .fault_o(l2_fault), .res_o(l2_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      va_q      <= '0;
      ttb_q     <= '0;
      l2_addr_q <= '0;
      dom_q     <= '0;
      res_q     <= '0;
      fault_q   <= 1'b0;
      flvl_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          ttb_q   <= ttb_i;
          state_q <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_gnt_i) state_q <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rvalid_i) begin
          unique case (l1_kind)
            K1_FAULT: begin
              fault_q <= 1'b1;
              flvl_q  <= 1'b0;
              dom_q   <= '0;
              res_q   <= '0;
              state_q <= S_DONE;
            end
            K1_SECT: begin
              fault_q <= 1'b0;
              flvl_q  <= 1'b0;
              dom_q   <= l1_dom;
              res_q   <= l1_sect;
              state_q <= S_DONE;
            end
            default: begin
              dom_q     <= l1_dom;
              l2_addr_q <= l1_l2_addr;
              state_q   <= S_L2_REQ;
            end
          endcase
        end
        S_L2_REQ: if (mem_gnt_i) state_q <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rvalid_i) begin
          fault_q <= l2_fault;
          flvl_q  <= 1'b1;
          res_q   <= l2_fault ? '0 : l2_res;
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == S_IDLE);
  assign mem_req_o    = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
  assign mem_addr_o   = (state_q == S_L2_REQ) ? l2_addr_q
                                              : {ttb_q[31:14], va_q[31:20], 2'b00};
  assign done_o       = (state_q == S_DONE);
  assign fault_o      = fault_q;
  assign fault_lvl_o  = flvl_q;
  assign pa_o         = res_q.pa;
  assign size_o       = res_q.size;
  assign domain_o     = dom_q;
  assign cacheable_o  = res_q.c;
  assign bufferable_o = res_q.b;
  assign ap_o         = res_q.ap;

  a_r13_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  a_r14_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_first_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> mem_req_o
      && mem_addr_o[31:14] == $past(ttb_i[31:14])
      && mem_addr_o[13:2] == $past(req_va_i[31:20]));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !done_o);

  a_r3_fault_only_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o && !fault_lvl_o |-> $past(mem_rvalid_i) && domain_o == '0);
endmodule

// File: tb/test_tt_walker.sv
module test_tt_walker;
  parameter int GNT_STALL = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ttb_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_va_i = '0;
  logic        req_ready_o, mem_req_o, mem_gnt_i, mem_rvalid_i;
  logic [31:0] mem_addr_o, mem_rdata_i;
  logic        done_o, fault_o, fault_lvl_o, cacheable_o, bufferable_o;
  logic [31:0] pa_o;
  logic [2:0]  size_o;
  logic [3:0]  domain_o;
  logic [1:0]  ap_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int          rd_n;
  logic [31:0] rd_addr [2];

  always #5 clk_i = ~clk_i;

  tt_walker i_tt_walker (
    .clk_i, .rst_ni, .ttb_i, .req_valid_i, .req_va_i, .req_ready_o,
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .done_o, .fault_o, .fault_lvl_o, .pa_o, .size_o, .domain_o,
    .cacheable_o, .bufferable_o, .ap_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drives one walk and plays the memory; returns after done_o is seen
  task automatic walk(logic [31:0] va, logic [31:0] d1, logic [31:0] d2, bit noise);
    int guard = 0;
    bit ok;
    logic [31:0] a;
    rd_n = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_va_i = va;
    @(negedge clk_i);
    if (noise) req_va_i = ~va; else req_valid_i = 1'b0;
    while (!done_o && guard < 200) begin
      if (mem_req_o) begin
        a = mem_addr_o; ok = 1;
        repeat (GNT_STALL) begin
          @(negedge clk_i);
          if (!mem_req_o || mem_addr_o !== a) ok = 0;
        end
        mem_gnt_i = 1'b1;
        @(negedge clk_i);
        mem_gnt_i = 1'b0; mem_rvalid_i = 1'b1;
        mem_rdata_i = (rd_n == 0) ? d1 : d2;
        if (rd_n < 2) rd_addr[rd_n] = a;
        rd_n++;
        chk("R13 request held until grant", {31'd0, ok}, 32'd1);
        @(negedge clk_i);
        mem_rvalid_i = 1'b0;
      end else begin
        @(negedge clk_i);
        guard++;
      end
    end
    req_valid_i = 1'b0;
    chk("R14 walk completes", {31'd0, done_o}, 32'd1);
  endtask

  function automatic logic [31:0] l1a(logic [31:0] va);
    return {ttb_i[31:14], va[31:20], 2'b00};
  endfunction

  task automatic t_reset();
    chk("R1 ready after reset", {31'd0, req_ready_o}, 32'd1);
    chk("R1 no read after reset", {31'd0, mem_req_o}, 32'd0);
    chk("R1 no done after reset", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_l1_fault();
    logic [31:0] va = 32'h1234_5678;
    walk(va, 32'hFFFF_FFFC, 32'h0, 0);
    chk("R2 first read address", rd_addr[0], l1a(va));
    chk("R3 single read", rd_n, 1);
    chk("R3 fault", {31'd0, fault_o}, 32'd1);
    chk("R3 fault level", {31'd0, fault_lvl_o}, 32'd0);
  endtask

  task automatic t_section();
    logic [31:0] va = 32'h123A_BCDE;
    logic [31:0] d1 = 32'hFED0_0000 | (32'd3 << 10) | (32'd9 << 5) | 32'h8 | 32'h2;
    walk(va, d1, 32'h0, 0);
    chk("R4 reads", rd_n, 1);
    chk("R4 fault", {31'd0, fault_o}, 32'd0);
    chk("R4 pa", pa_o, {d1[31:20], va[19:0]});
    chk("R4 size", {29'd0, size_o}, 32'd3);
    chk("R4 domain", {28'd0, domain_o}, 32'd9);
    chk("R4 cb", {30'd0, cacheable_o, bufferable_o}, 32'd2);
    chk("R4 ap", {30'd0, ap_o}, 32'd3);
  endtask

  task automatic t_super();
    logic [31:0] va = 32'h1234_5678;
    logic [31:0] d1 = 32'hA500_0000 | (32'd1 << 18) | (32'd1 << 10) | (32'd5 << 5) | 32'h4 | 32'h2;
    walk(va, d1, 32'h0, 0);
    chk("R5 pa", pa_o, {d1[31:24], va[23:0]});
    chk("R5 size", {29'd0, size_o}, 32'd4);
    chk("R5 domain", {28'd0, domain_o}, 32'd5);
    chk("R5 cb", {30'd0, cacheable_o, bufferable_o}, 32'd1);
    chk("R5 ap", {30'd0, ap_o}, 32'd1);
  endtask

  task automatic t_coarse_small();
    logic [31:0] va = 32'h0056_7ABC;
    logic [31:0] d1 = 32'h3000_0400 | (32'd7 << 5) | 32'h1;
    logic [31:0] d2 = 32'h89AB_C000 | 32'hE40 | 32'h8 | 32'h2;
    walk(va, d1, d2, 0);
    chk("R6 reads", rd_n, 2);
    chk("R6 second read address", rd_addr[1], {d1[31:10], va[19:12], 2'b00});
    chk("R10 pa", pa_o, {d2[31:12], va[11:0]});
    chk("R10 size", {29'd0, size_o}, 32'd1);
    chk("R10 ap subpage 2", {30'd0, ap_o}, 32'd2);
    chk("R12 domain from first level", {28'd0, domain_o}, 32'd7);
    chk("R12 cb from second level", {30'd0, cacheable_o, bufferable_o}, 32'd2);
  endtask

  task automatic t_coarse_large();
    logic [31:0] va = 32'h0ABC_DEF0;
    logic [31:0] d1 = 32'h3000_0800 | (32'd3 << 5) | 32'h1;
    logic [31:0] d2 = 32'h7654_0000 | 32'hE40 | 32'h4 | 32'h1;
    walk(va, d1, d2, 0);
    chk("R6 second read address", rd_addr[1], {d1[31:10], va[19:12], 2'b00});
    chk("R9 pa", pa_o, {d2[31:16], va[15:0]});
    chk("R9 size", {29'd0, size_o}, 32'd2);
    chk("R9 ap subpage 3", {30'd0, ap_o}, 32'd3);
    chk("R12 cb", {30'd0, cacheable_o, bufferable_o}, 32'd1);
  endtask

  task automatic t_fine_tiny();
    logic [31:0] va = 32'h00F1_2F45;
    logic [31:0] d1 = 32'h4444_5000 | (32'd2 << 5) | 32'h3;
    logic [31:0] d2 = 32'h1357_2400 | (32'd1 << 4) | (32'd2 << 6) | (32'd3 << 10) | 32'hC | 32'h3;
    walk(va, d1, d2, 0);
    chk("R7 second read address", rd_addr[1], {d1[31:12], va[19:10], 2'b00});
    chk("R11 pa", pa_o, {d2[31:10], va[9:0]});
    chk("R11 size", {29'd0, size_o}, 32'd0);
    chk("R11 ap first field", {30'd0, ap_o}, 32'd1);
    chk("R12 domain", {28'd0, domain_o}, 32'd2);
  endtask

  task automatic t_l2_fault();
    logic [31:0] va = 32'h7777_1234;
    logic [31:0] d1 = 32'h2000_0C00 | (32'd12 << 5) | 32'h1;
    walk(va, d1, 32'hFFFF_FFFC, 0);
    chk("R8 reads", rd_n, 2);
    chk("R8 fault", {31'd0, fault_o}, 32'd1);
    chk("R8 fault level", {31'd0, fault_lvl_o}, 32'd1);
  endtask

  task automatic t_busy();
    logic [31:0] va = 32'h0420_1357;
    logic [31:0] d1 = 32'h5550_0000 | (32'd2 << 10) | (32'd4 << 5) | 32'h2;
    walk(va, d1, 32'h0, 1);
    chk("R14 first read unaffected", rd_addr[0], l1a(va));
    chk("R14 single read despite request", rd_n, 1);
    chk("R14 result unaffected", pa_o, {d1[31:20], va[19:0]});
    @(negedge clk_i);
    chk("R14 done one cycle", {31'd0, done_o}, 32'd0);
    repeat (3) begin
      @(negedge clk_i);
      chk("R14 no stray read", {31'd0, mem_req_o}, 32'd0);
    end
  endtask

  initial begin
    mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    ttb_i = 32'h8765_7FFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_l1_fault();
    t_section();
    t_super();
    t_coarse_small();
    t_coarse_large();
    t_fine_tiny();
    t_l2_fault();
    t_busy();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R14 watchdog expired act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule